// File: doc/BRIEF.md
# Frame-Transfer Area Sensor Vertical Sequencer

This block drives the vertical side of a four-phase frame-transfer area sensor that has a light-exposed image section and a shielded storage section. When a frame is requested, it can first pulse a substrate charge reset to empty the image section. It then counts out an integration time, moves image lines toward storage, and brings stored lines one at a time into the horizontal register. After each line arrives there, it signals a separate line-readout sequencer and waits for that sequencer to finish the line.

In still mode every image line is read out. The store is shorter than the frame, so it is first filled with both sections shifting together. After that, each readout shift moves the image and storage sections as one pass-through stage until the image section is empty, and then moves the storage section alone. A shutter-close request is raised a fixed time before the first transfer and held until the frame ends. In monitor mode, a programmable number of image lines are summed into each storage line. Only one section shifts at a time in this mode. The reduced frame is parked at the bottom of the store and then read out line by line.

Every line handed off carries its readout index, a parity bit and a class tag: black reference, active, or dummy. The outputs are logic-level phase enables. Drive levels and shutter mechanics belong to other blocks.

Top module: `ftccd_vseq`

## Requirements
- R1: After reset, and whenever no frame is in progress, all phase enables, charge_reset, shutter_close, line_start, frame_done and busy are low.
- R2: A frame_start seen while idle latches all configuration inputs. If cr_enable is 1, charge_reset is high for exactly max(cr_cycles,1) cycles starting the cycle after frame_start is sampled, and no phase is active while it is high. If cr_enable is 0, charge_reset stays low.
- R3: The first phase enable appears max(integ_cycles,1) cycles after the charge-reset interval ends, or after frame_start when there is no charge reset. In still mode a further SHUT_WAIT cycles are added.
- R4: Each line shift lasts exactly 4 consecutive cycles. The active section's phase enable is one-hot and steps bit0, bit1, bit2, bit3, one bit per cycle.
- R5: In still mode shutter_close rises SHUT_WAIT cycles before the first shift and stays high through frame_done. The frame has TOTAL image shifts and STORE_LINES+TOTAL storage shifts. Exactly TOTAL of these shifts move both sections together: the first STORE_LINES (with no line handed off) and the first TOTAL-STORE_LINES readout shifts.
- R6: In still mode TOTAL lines are handed off with line_index 0 to TOTAL-1 in order. Image line k is tagged from its position in the image section.
- R7: The image section is ordered as TOP_BLACK black lines, ACTIVE active lines, BOT_BLACK black lines, then DUMMY dummy lines. line_tag encodes 2'b00 black, 2'b01 active, 2'b10 dummy, and line_odd equals bit 0 of line_index.
- R8: In monitor mode, with N = merge_factor and M = monitor_lines (M ≤ STORE_LINES, N·M ≤ TOTAL), each storage line takes N image-only shifts followed by one storage-only shift. This is repeated M times, then STORE_LINES-M storage-only parking shifts follow, then M storage-only readout shifts. The two sections never shift together in this mode.
- R9: In monitor mode, line j (0 to M-1) is handed off with line_index j and carries the tag of image line j·N.
- R10: line_start is a one-cycle pulse in the cycle after each readout shift. No phase is active until line_done is seen in a later cycle, and line_done is ignored at any other time.
- R11: frame_done is a one-cycle pulse in the cycle after the last line's line_done is taken. busy is low in the cycle after it.
- R12: A frame_start or configuration change while busy has no effect on the running frame and does not start another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Request a frame (taken only when idle) |
| monitor_mode | input | 1 | 1 selects monitor readout, 0 selects still readout |
| cr_enable | input | 1 | Issue a charge-reset pulse before integration |
| cr_cycles | input | CNT_W | Charge-reset length in cycles |
| integ_cycles | input | CNT_W | Integration length in cycles |
| merge_factor | input | MERGE_W | Image lines summed per storage line (monitor) |
| monitor_lines | input | LINE_W | Storage lines in a monitor frame |
| line_done | input | 1 | Line-readout sequencer finished the current line |
| a_phase | output | NPH | Image-section phase enables |
| b_phase | output | NPH | Storage-section phase enables |
| charge_reset | output | 1 | Substrate charge-reset pulse |
| shutter_close | output | 1 | Request that the mechanical shutter be closed |
| line_start | output | 1 | A line is in the horizontal register |
| line_index | output | LINE_W | Readout index of the line |
| line_tag | output | 2 | Line class: 00 black, 01 active, 10 dummy |
| line_odd | output | 1 | Parity of line_index |
| busy | output | 1 | A frame is in progress |
| frame_done | output | 1 | Last line of the frame has been read |

## Verification
The properties assume that line_done comes only as an answer to line_start, and that in monitor mode merge_factor and monitor_lines describe a frame that fits: at most the store depth, with their product at most the image height. They also assume cr_cycles, integ_cycles and merge_factor are nonzero. The bench raises line_done one or more cycles after it sees line_start, picks only fitting monitor settings, and ranges them over frames with and without parking shifts. It also injects a stray line_done, a second frame_start and altered configuration inputs while a frame runs. These disturbances stay within what the design must ignore.

// File: rtl/ftccd_vseq_pkg.sv
package ftccd_vseq_pkg;

    typedef enum logic [1:0] {
        TAG_BLACK  = 2'b00,
        TAG_ACTIVE = 2'b01,
        TAG_DUMMY  = 2'b10
    } line_tag_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CRST,
        ST_INTEG,
        ST_SHUTW,
        ST_FILL,
        ST_MERGE,
        ST_MADV,
        ST_PARK,
        ST_RSHIFT,
        ST_RSTART,
        ST_RWAIT,
        ST_DONE
    } vseq_state_e;

endpackage

// File: rtl/ftccd_phase_rot.sv
module ftccd_phase_rot #(
    parameter int NPH = 4,
    localparam int SW = (NPH > 1) ? $clog2(NPH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    output logic [NPH-1:0] ph,
    output logic           last
);

    logic [SW-1:0] step_d, step_q;

    always_comb begin
        if (!run || step_q == SW'(NPH - 1)) begin
            step_d = '0;
        end else begin
            step_d = step_q + SW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
        end else begin
            step_q <= step_d;
        end
    end

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        assign ph[i] = run && (step_q == SW'(i));
    end

    assign last = run && (step_q == SW'(NPH - 1));

endmodule

// File: rtl/ftccd_line_class.sv
module ftccd_line_class
    import ftccd_vseq_pkg::*;
#(
    parameter int TOP_BLACK = 12,
    parameter int ACTIVE    = 1296,
    parameter int BOT_BLACK = 12,
    parameter int LINE_W    = 11
) (
    input  logic [LINE_W-1:0] img_line,
    output line_tag_e         tag
);

    localparam logic [LINE_W-1:0] ACT_BEGIN = LINE_W'(TOP_BLACK);
    localparam logic [LINE_W-1:0] ACT_END   = LINE_W'(TOP_BLACK + ACTIVE);
    localparam logic [LINE_W-1:0] BLK_END   = LINE_W'(TOP_BLACK + ACTIVE + BOT_BLACK);

    always_comb begin
        if (img_line < ACT_BEGIN) begin
            tag = TAG_BLACK;
        end else if (img_line < ACT_END) begin
            tag = TAG_ACTIVE;
        end else if (img_line < BLK_END) begin
            tag = TAG_BLACK;
        end else begin
            tag = TAG_DUMMY;
        end
    end

endmodule

// File: rtl/ftccd_vseq.sv
module ftccd_vseq
    import ftccd_vseq_pkg::*;
#(
    parameter int TOP_BLACK   = 12,
    parameter int ACTIVE      = 1296,
    parameter int BOT_BLACK   = 12,
    parameter int DUMMY       = 4,
    parameter int STORE_LINES = 298,
    parameter int NPH         = 4,
    parameter int CNT_W       = 16,
    parameter int MERGE_W     = 4,
    parameter int SHUT_WAIT   = 8,
    localparam int TOTAL_LINES = TOP_BLACK + ACTIVE + BOT_BLACK + DUMMY,
    localparam int LINE_W      = $clog2(TOTAL_LINES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               monitor_mode,
    input  logic               cr_enable,
    input  logic [CNT_W-1:0]   cr_cycles,
    input  logic [CNT_W-1:0]   integ_cycles,
    input  logic [MERGE_W-1:0] merge_factor,
    input  logic [LINE_W-1:0]  monitor_lines,
    input  logic               line_done,
    output logic [NPH-1:0]     a_phase,
    output logic [NPH-1:0]     b_phase,
    output logic               charge_reset,
    output logic               shutter_close,
    output logic               line_start,
    output logic [LINE_W-1:0]  line_index,
    output logic [1:0]         line_tag,
    output logic               line_odd,
    output logic               busy,
    output logic               frame_done
);

    localparam logic [LINE_W-1:0] TOTAL_L  = LINE_W'(TOTAL_LINES);
    localparam logic [LINE_W-1:0] STORE_L  = LINE_W'(STORE_LINES);
    localparam logic [LINE_W-1:0] PASS_L   = LINE_W'(TOTAL_LINES - STORE_LINES);
    localparam logic [CNT_W-1:0]  SHUTW_L  = CNT_W'(SHUT_WAIT);

    typedef struct packed {
        vseq_state_e        st;
        logic               mon;
        logic               cr_en;
        logic [CNT_W-1:0]   cr_len;
        logic [CNT_W-1:0]   integ;
        logic [MERGE_W-1:0] nmerge;
        logic [LINE_W-1:0]  mlines;
        logic [CNT_W-1:0]   cnt;
        logic [LINE_W-1:0]  line;
        logic [MERGE_W-1:0] sub;
        logic [LINE_W-1:0]  acc;
    } ctl_t;

    ctl_t r_d, r_q;

    logic            a_sel, b_sel, rot_run, rot_last;
    logic [NPH-1:0]  rot_ph;
    logic [LINE_W-1:0] img_line;
    line_tag_e       tag_w;
    logic            mon_flag;

    function automatic logic cnt_end(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] len);
        return ({1'b0, c} + (CNT_W + 1)'(1)) >= {1'b0, len};
    endfunction

    function automatic logic line_end(input logic [LINE_W-1:0] l, input logic [LINE_W-1:0] len);
        return ({1'b0, l} + (LINE_W + 1)'(1)) >= {1'b0, len};
    endfunction

    // section selection decoded from the registered state
    always_comb begin
        a_sel = 1'b0;
        b_sel = 1'b0;
        case (r_q.st)
            ST_FILL:   begin a_sel = 1'b1; b_sel = 1'b1; end
            ST_MERGE:  a_sel = 1'b1;
            ST_MADV:   b_sel = 1'b1;
            ST_PARK:   b_sel = 1'b1;
            ST_RSHIFT: begin
                b_sel = 1'b1;
                a_sel = !r_q.mon && (r_q.line < PASS_L);
            end
            default: ;
        endcase
    end

    assign rot_run = a_sel || b_sel;

    ftccd_phase_rot #(.NPH(NPH)) u_rot (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (rot_run),
        .ph    (rot_ph),
        .last  (rot_last)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (frame_start) begin
                    r_d.mon    = monitor_mode;
                    r_d.cr_en  = cr_enable;
                    r_d.cr_len = cr_cycles;
                    r_d.integ  = integ_cycles;
                    r_d.nmerge = merge_factor;
                    r_d.mlines = monitor_lines;
                    r_d.cnt    = '0;
                    r_d.line   = '0;
                    r_d.sub    = '0;
                    r_d.acc    = '0;
                    r_d.st     = cr_enable ? ST_CRST : ST_INTEG;
                end
            end
            ST_CRST: begin
                if (cnt_end(r_q.cnt, r_q.cr_len)) begin
                    r_d.cnt = '0;
                    r_d.st  = ST_INTEG;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_INTEG: begin
                if (cnt_end(r_q.cnt, r_q.integ)) begin
                    r_d.cnt = '0;
                    r_d.st  = r_q.mon ? ST_MERGE : ST_SHUTW;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_SHUTW: begin
                if (cnt_end(r_q.cnt, SHUTW_L)) begin
                    r_d.cnt = '0;
                    r_d.st  = ST_FILL;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_FILL: begin
                if (rot_last) begin
                    if (line_end(r_q.line, STORE_L)) begin
                        r_d.line = '0;
                        r_d.st   = ST_RSHIFT;
                    end else begin
                        r_d.line = r_q.line + LINE_W'(1);
                    end
                end
            end
            ST_MERGE: begin
                if (rot_last) begin
                    if (({1'b0, r_q.sub} + (MERGE_W + 1)'(1)) >= {1'b0, r_q.nmerge}) begin
                        r_d.sub = '0;
                        r_d.st  = ST_MADV;
                    end else begin
                        r_d.sub = r_q.sub + MERGE_W'(1);
                    end
                end
            end
            ST_MADV: begin
                if (rot_last) begin
                    if (line_end(r_q.line, r_q.mlines)) begin
                        r_d.line = '0;
                        r_d.st   = (r_q.mlines >= STORE_L) ? ST_RSHIFT : ST_PARK;
                    end else begin
                        r_d.line = r_q.line + LINE_W'(1);
                        r_d.st   = ST_MERGE;
                    end
                end
            end
            ST_PARK: begin
                if (rot_last) begin
                    if (({1'b0, r_q.line} + {1'b0, r_q.mlines} + (LINE_W + 1)'(1)) >= {1'b0, STORE_L}) begin
                        r_d.line = '0;
                        r_d.st   = ST_RSHIFT;
                    end else begin
                        r_d.line = r_q.line + LINE_W'(1);
                    end
                end
            end
            ST_RSHIFT: begin
                if (rot_last) begin
                    r_d.st = ST_RSTART;
                end
            end
            ST_RSTART: begin
                r_d.st = ST_RWAIT;
            end
            ST_RWAIT: begin
                if (line_done) begin
                    if (line_end(r_q.line, r_q.mon ? r_q.mlines : TOTAL_L)) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.line = r_q.line + LINE_W'(1);
                        r_d.acc  = r_q.acc + LINE_W'(r_q.nmerge);
                        r_d.st   = ST_RSHIFT;
                    end
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign img_line = r_q.mon ? r_q.acc : r_q.line;

    ftccd_line_class #(
        .TOP_BLACK (TOP_BLACK),
        .ACTIVE    (ACTIVE),
        .BOT_BLACK (BOT_BLACK),
        .LINE_W    (LINE_W)
    ) u_class (
        .img_line (img_line),
        .tag      (tag_w)
    );

    assign a_phase      = rot_ph & {NPH{a_sel}};
    assign b_phase      = rot_ph & {NPH{b_sel}};
    assign charge_reset = (r_q.st == ST_CRST);
    assign shutter_close = !r_q.mon &&
                           (r_q.st == ST_SHUTW || r_q.st == ST_FILL || r_q.st == ST_RSHIFT ||
                            r_q.st == ST_RSTART || r_q.st == ST_RWAIT || r_q.st == ST_DONE);
    assign line_start   = (r_q.st == ST_RSTART);
    assign line_index   = r_q.line;
    assign line_tag     = tag_w;
    assign line_odd     = r_q.line[0];
    assign busy         = (r_q.st != ST_IDLE);
    assign frame_done   = (r_q.st == ST_DONE);
    assign mon_flag     = r_q.mon;

endmodule

// File: rtl/ftccd_vseq_chk.sv
module ftccd_vseq_chk #(
    parameter int NPH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NPH-1:0] a_phase,
    input logic [NPH-1:0] b_phase,
    input logic           charge_reset,
    input logic           shutter_close,
    input logic           line_start,
    input logic           frame_done,
    input logic           busy,
    input logic           mon_mode
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (a_phase == '0 && b_phase == '0 && !charge_reset && !shutter_close && !line_start)); // R1

    AST_CR_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        charge_reset |-> (a_phase == '0 && b_phase == '0 && !line_start)); // R2

    AST_PH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0(a_phase) && $onehot0(b_phase))); // R4

    AST_A_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_phase != '0 && !a_phase[NPH-1]) |=> (a_phase == ($past(a_phase) << 1))); // R4

    AST_B_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (b_phase != '0 && !b_phase[NPH-1]) |=> (b_phase == ($past(b_phase) << 1))); // R4

    AST_STILL_SHUTTER: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mon_mode && (a_phase != '0 || b_phase != '0)) |-> shutter_close); // R5

    AST_MON_ONE_SECTION: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mon_mode) |-> !(a_phase != '0 && b_phase != '0)); // R8

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (!line_start && a_phase == '0 && b_phase == '0)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (!frame_done && !busy)); // R11

endmodule

bind ftccd_vseq ftccd_vseq_chk #(.NPH(NPH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .a_phase       (a_phase),
    .b_phase       (b_phase),
    .charge_reset  (charge_reset),
    .shutter_close (shutter_close),
    .line_start    (line_start),
    .frame_done    (frame_done),
    .busy          (busy),
    .mon_mode      (mon_flag)
);

// File: tb/ftccd_vseq_test.sv
`timescale 1ns/1ps
module ftccd_vseq_test;

    localparam int CLK_PERIOD = 10;
    localparam int TOPB  = 2;
    localparam int ACT   = 8;
    localparam int BOTB  = 2;
    localparam int DUM   = 1;
    localparam int STORE = 6;
    localparam int SW    = 3;
    localparam int CW    = 8;
    localparam int MW    = 4;
    localparam int TOTAL = TOPB + ACT + BOTB + DUM;
    localparam int LW    = $clog2(TOTAL + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          monitor_mode = 1'b0;
    logic          cr_enable = 1'b0;
    logic [CW-1:0] cr_cycles = '0;
    logic [CW-1:0] integ_cycles = '0;
    logic [MW-1:0] merge_factor = '0;
    logic [LW-1:0] monitor_lines = '0;
    logic          ld_resp = 1'b0;
    logic          ld_extra = 1'b0;
    logic          line_done;
    logic [3:0]    a_phase, b_phase;
    logic          charge_reset, shutter_close, line_start, line_odd, busy, frame_done;
    logic [LW-1:0] line_index;
    logic [1:0]    line_tag;

    assign line_done = ld_resp | ld_extra;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ftccd_vseq #(
        .TOP_BLACK (TOPB), .ACTIVE (ACT), .BOT_BLACK (BOTB), .DUMMY (DUM),
        .STORE_LINES (STORE), .NPH (4), .CNT_W (CW), .MERGE_W (MW), .SHUT_WAIT (SW)
    ) uut (
        .clk (clk), .rst_n (rst_n), .frame_start (frame_start), .monitor_mode (monitor_mode),
        .cr_enable (cr_enable), .cr_cycles (cr_cycles), .integ_cycles (integ_cycles),
        .merge_factor (merge_factor), .monitor_lines (monitor_lines), .line_done (line_done),
        .a_phase (a_phase), .b_phase (b_phase), .charge_reset (charge_reset),
        .shutter_close (shutter_close), .line_start (line_start), .line_index (line_index),
        .line_tag (line_tag), .line_odd (line_odd), .busy (busy), .frame_done (frame_done)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_tag(input int img);
        if (img < TOPB) return 0;
        if (img < TOPB + ACT) return 1;
        if (img < TOPB + ACT + BOTB) return 0;
        return 2;
    endfunction

    typedef struct { int idx; int tag; int odd; } line_item_t;
    line_item_t exp_q[$];

    int resp_dly = 1;

    // per-frame observations, cleared when a frame is accepted
    int lat, cr_cnt, a_cnt, b_cnt, both_cnt, sh_pre, done_cnt, line_cnt, wait_viol, sh_at_done;
    bit first_seen, waiting;

    // monitor and scoreboard, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_start && !busy) begin
                lat = 0; cr_cnt = 0; a_cnt = 0; b_cnt = 0; both_cnt = 0; sh_pre = 0;
                done_cnt = 0; line_cnt = 0; wait_viol = 0; sh_at_done = -1;
                first_seen = 1'b0; waiting = 1'b0;
            end else begin
                if (charge_reset) cr_cnt++;
                if (!first_seen) begin
                    if (a_phase != 4'b0 || b_phase != 4'b0) first_seen = 1'b1;
                    else begin
                        lat++;
                        if (shutter_close) sh_pre++;
                    end
                end
                if (a_phase == 4'b1000) a_cnt++;
                if (b_phase == 4'b1000) b_cnt++;
                if (a_phase == 4'b1000 && b_phase == 4'b1000) both_cnt++;
                if (waiting && (a_phase != 4'b0 || b_phase != 4'b0)) wait_viol++;
                if (waiting && line_done) waiting = 1'b0;
                if (frame_done) begin
                    done_cnt++;
                    sh_at_done = int'(shutter_close);
                end
                if (line_start) begin
                    line_cnt++;
                    waiting = 1'b1;
                    if (exp_q.size() == 0) begin
                        check_eq("R10", "unexpected line_start", 1, 0);
                    end else begin
                        line_item_t e;
                        e = exp_q.pop_front();
                        check_eq("R6", "line_index", int'(line_index), e.idx);
                        check_eq("R7", "line_tag", int'(line_tag), e.tag);
                        check_eq("R7", "line_odd", int'(line_odd), e.odd);
                    end
                end
            end
        end
    end

    // line-readout responder
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && line_start) begin
                repeat (resp_dly) @(posedge clk);
                #1 ld_resp = 1'b1;
                @(posedge clk);
                #1 ld_resp = 1'b0;
            end
        end
    end

    // driver: push expected lines
    task automatic push_expect(input bit mon, input int n, input int m);
        if (!mon) begin
            for (int k = 0; k < TOTAL; k++) exp_q.push_back('{k, exp_tag(k), k % 2});
        end else begin
            for (int j = 0; j < m; j++) exp_q.push_back('{j, exp_tag(j * n), j % 2});
        end
    endtask

    task automatic run_frame(input bit mon, input int n, input int m, input bit cren,
                             input int crl, input int integ, input int dly, input bit disturb);
        int guard;
        int exp_lat;
        @(posedge clk); #1;
        monitor_mode  = mon;
        merge_factor  = MW'(n);
        monitor_lines = LW'(m);
        cr_enable     = cren;
        cr_cycles     = CW'(crl);
        integ_cycles  = CW'(integ);
        resp_dly      = dly;
        push_expect(mon, n, m);
        frame_start   = 1'b1;
        @(posedge clk); #1;
        frame_start   = 1'b0;
        if (disturb) begin
            @(posedge clk); #1;
            ld_extra = 1'b1; frame_start = 1'b1;
            monitor_mode = ~mon; merge_factor = MW'(n + 1); monitor_lines = LW'(2);
            cr_enable = ~cren;
            @(posedge clk); #1;
            ld_extra = 1'b0; frame_start = 1'b0;
        end
        guard = 0;
        while (done_cnt == 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
        exp_lat = (cren ? crl : 0) + integ + (mon ? 0 : SW);
        check_eq("R2", "charge_reset cycles", cr_cnt, cren ? crl : 0);
        check_eq("R3", "cycles to first phase", lat, exp_lat);
        check_eq("R5", "shutter cycles before first shift", sh_pre, mon ? 0 : SW);
        check_eq(mon ? "R8" : "R5", "image shifts", a_cnt, mon ? n * m : TOTAL);
        check_eq(mon ? "R8" : "R5", "storage shifts", b_cnt, mon ? STORE + m : STORE + TOTAL);
        check_eq(mon ? "R8" : "R5", "joint shifts", both_cnt, mon ? 0 : TOTAL);
        check_eq(mon ? "R9" : "R6", "lines handed off", line_cnt, mon ? m : TOTAL);
        check_eq("R10", "phase while waiting for line_done", wait_viol, 0);
        check_eq("R11", "frame_done pulses", done_cnt, 1);
        check_eq("R5", "shutter at frame_done", sh_at_done, mon ? 0 : 1);
        check_eq("R11", "busy after frame", int'(busy), 0);
        check_eq("R12", "scoreboard left over", exp_q.size(), 0);
        exp_q.delete();
        monitor_mode = mon; cr_enable = cren;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check_eq("R1", "a_phase at reset", int'(a_phase), 0);
        check_eq("R1", "b_phase at reset", int'(b_phase), 0);
        check_eq("R1", "busy at reset", int'(busy), 0);
        check_eq("R1", "charge_reset at reset", int'(charge_reset), 0);
        check_eq("R1", "shutter_close at reset", int'(shutter_close), 0);
        check_eq("R1", "line_start at reset", int'(line_start), 0);
        check_eq("R1", "frame_done at reset", int'(frame_done), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        run_frame(1'b0, 1, 0, 1'b1, 3, 5, 1, 1'b0);   // still, with charge reset
        run_frame(1'b1, 2, 4, 1'b0, 0, 4, 3, 1'b1);   // monitor, parking, disturbed mid-frame
        run_frame(1'b1, 2, 6, 1'b1, 1, 2, 1, 1'b0);   // monitor filling the whole store
        run_frame(1'b1, 1, 3, 1'b0, 0, 1, 2, 1'b0);   // monitor, no merging
        run_frame(1'b0, 1, 0, 1'b0, 0, 1, 2, 1'b1);   // still, disturbed mid-frame

        repeat (6) @(negedge clk);
        check_eq("R12", "busy after ignored requests", int'(busy), 0);
        check_eq("R1", "phases idle after frames", int'(a_phase | b_phase), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog R11 frame did not complete act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule